// File: doc/BRIEF.md
# Software Self-Test Infrastructure Controller

This block sits beside an embedded processor and its memories. It lets external test equipment run a software self-test without any change to the processor core. The tester sends short serial commands, each an opcode followed by an operand. To load a test program, the block requests the system bus and writes the program words into instruction memory. To start the test, it raises an interrupt, and the self-test program runs as the service routine of that interrupt.

While the test runs, the block watches the processor's write traffic. Every value written to one dedicated output-port address is folded into a 16-bit signature register. A reserved marker value written to a separate completion address ends the run. The tester can read the current status and the final signature serially. A programmable address-match trigger can also raise the interrupt for debug use.

Top module: `sbst_ctrl`

## Requirements
- R1: After reset, `irq`, `bus_req` and `bus_we` are low. A status read returns 0 (IDLE) and a result read returns 0x0000.
- R2: A command is 24 bits shifted in on `tc_si`, least significant bit first, one bit per cycle while `tc_shift` is high. It is applied in the cycle `tc_update` is high. Bits 7:0 are the opcode and bits 23:8 the operand. The opcodes are 0x01 load (operand = word count), 0x05 program word, 0x02 run, 0x03 read status, 0x04 read result and 0x06 set trigger address.
- R3: A load command with a nonzero count, given in IDLE or DONE, sets the status to LOADING (1) and raises `bus_req` in the next cycle.
- R4: Each program-word command given while LOADING produces exactly one `bus_we` cycle. That write carries the operand on `bus_wdata` and the address LOAD_BASE+k on `bus_addr`, where k is the word's index. LOAD_BASE defaults to 0. When `bus_we` is low, `bus_addr` and `bus_wdata` are zero.
- R5: No write is issued while `bus_gnt` is low. A pending word waits until the grant arrives.
- R6: After the last counted word is written, `bus_req` falls on the next cycle and the status returns to IDLE (0).
- R7: A run command given in IDLE or DONE clears the signature to 0x0000, sets the status to RUNNING (2) and raises `irq`. `irq` then stays high until a cycle with `irq_ack` high.
- R8: While RUNNING, each cycle with `cpu_valid`, `cpu_we` and `cpu_addr` equal to PORT_ADDR (0xFF00) updates the signature as sig = (sig<<1) ^ (sig[15] ? 0x1021 : 0) ^ `cpu_wdata`. Such writes in any other state leave the signature unchanged.
- R9: While RUNNING, a write of 0xA5A5 to STAT_ADDR (0xFF02) sets the status to DONE (3) and does not enter the signature. Any other value written there has no effect.
- R10: While RUNNING, every command except read status is ignored.
- R11: A read status command loads the 2-bit status, zero-extended to 16 bits, into the output shifter. A read result command loads the signature. `tc_so` shows bit 0 from the cycle after the update, and each `tc_shift` cycle advances it by one bit, least significant bit first.
- R12: A set-trigger command, given outside RUNNING, arms a one-shot trigger on the operand address. The first cycle with `cpu_valid` high and `cpu_addr` equal to that address raises `irq`. Later matches do nothing until the trigger is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tc_si | input | 1 | Serial command input |
| tc_shift | input | 1 | Shift enable for command and readout shifters |
| tc_update | input | 1 | Apply the shifted-in command |
| tc_so | output | 1 | Serial readout bit |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_addr | output | 16 | Instruction-memory write address |
| bus_wdata | output | 16 | Program word being written |
| bus_we | output | 1 | Write strobe, one cycle per word |
| irq | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| cpu_valid | input | 1 | Processor bus access valid |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor access address |
| cpu_wdata | input | 16 | Processor write data |

## Verification
A wrong state in the controller shows up at the ports within a cycle or two of the next command. A stuck LOADING state keeps `bus_req` high after the last word. A missed transition to RUNNING leaves `irq` low. A missed marker keeps read-result commands ignored, so they return shifted-out zeros. Signature faults stay hidden until a result read. For that reason the bench mixes port data with high bit 15 set, checks that marker and non-marker writes do not enter the signature, and checks that the signature clears on each new run.

// File: rtl/sbst_pkg.sv
// Shared types and command opcodes of the self-test controller.
package sbst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } sbst_state_e;

    localparam logic [7:0] OP_LOAD = 8'h01;
    localparam logic [7:0] OP_RUN  = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h03;
    localparam logic [7:0] OP_RSLT = 8'h04;
    localparam logic [7:0] OP_DATA = 8'h05;
    localparam logic [7:0] OP_TRIG = 8'h06;
endpackage

// File: rtl/sbst_cmd_port.sv
// Serial command port.
// Shifts in an opcode and operand LSB first and presents them on an update strobe.
// Holds a readout shifter that is loaded in parallel and shifted out LSB first.
// Assumes update and shift are never high in the same cycle.
module sbst_cmd_port #(
    parameter int OPW  = 8,
    parameter int ARGW = 16,
    parameter int OUTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            si,
    input  logic            shift,
    input  logic            update,
    input  logic            out_load,
    input  logic [OUTW-1:0] out_val,
    output logic            so,
    output logic            cmd_valid,
    output logic [OPW-1:0]  cmd_op,
    output logic [ARGW-1:0] cmd_arg
);
    localparam int CMDW = OPW + ARGW;

    logic [CMDW-1:0] cmd_sr;
    logic [OUTW-1:0] out_sr;

    // Command shifter: new bits enter at the top, so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_sr <= '0;
        else if (shift) cmd_sr <= {si, cmd_sr[CMDW-1:1]};
    end

    // Readout shifter: parallel load wins over shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_sr <= '0;
        else if (out_load) out_sr <= out_val;
        else if (shift)    out_sr <= {1'b0, out_sr[OUTW-1:1]};
    end

    assign so        = out_sr[0];
    assign cmd_valid = update;
    assign cmd_op    = cmd_sr[OPW-1:0];
    assign cmd_arg   = cmd_sr[CMDW-1:OPW];

    AST_OUT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        out_load |=> (so == $past(out_val[0]))); // R11
endmodule

// File: rtl/sbst_loader.sv
// Program loader and bus master.
// Writes one buffered word per grant cycle to consecutive addresses from BASE.
// Assumes the owner starts it only with a nonzero count.
// Holds at most one pending word; words offered while one is pending are dropped.
module sbst_loader #(
    parameter int          AW   = 16,
    parameter int          DW   = 16,
    parameter int          CW   = 16,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          word_valid,
    input  logic [DW-1:0] word,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          last_write
);
    logic [CW-1:0] remain;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wbuf;
    logic          pending;
    logic          fire;

    assign fire       = pending && bus_gnt && bus_req;
    assign last_write = fire && (remain == CW'(1));

    // Word buffer: capture an offered word, release it on a granted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            wbuf    <= '0;
        end else if (fire) begin
            pending <= 1'b0;
        end else if (word_valid && !pending) begin
            pending <= 1'b1;
            wbuf    <= word;
        end
    end

    // Request, address and remaining-count bookkeeping for the load sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req <= 1'b0;
            remain  <= '0;
            wr_addr <= BASE;
        end else if (start) begin
            bus_req <= (count != '0);
            remain  <= count;
            wr_addr <= BASE;
        end else if (fire) begin
            remain  <= remain - CW'(1);
            wr_addr <= wr_addr + AW'(1);
            if (remain == CW'(1)) bus_req <= 1'b0;
        end
    end

    assign bus_we    = fire;
    assign bus_addr  = fire ? wr_addr : '0;
    assign bus_wdata = fire ? wbuf : '0;

    AST_WE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_gnt); // R5
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        last_write |=> !bus_req); // R6
endmodule

// File: rtl/sbst_misr.sv
// Multiple-input signature register, Galois form.
// Clear has priority over an update in the same cycle.
module sbst_misr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);
    logic [W-1:0] nxt;

    // Next signature: shift, fold feedback through the polynomial, mix in data.
    always_comb begin
        nxt = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ din;
    end

    // Signature state register.
    always_ff @(posedge clk) begin
        if (!rst_n)     sig <= '0;
        else if (clear) sig <= '0;
        else if (en)    sig <= nxt;
    end

    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !en) |=> $stable(sig)); // R8
    AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig == '0)); // R7
endmodule

// File: rtl/sbst_ctrl.sv
// Self-test controller top.
// Decodes serial commands, sequences the state machine, drives the interrupt,
// compacts port writes and runs the one-shot debug trigger.
// Assumes the processor bus inputs are synchronous to clk and AW <= DW.
module sbst_ctrl #(
    parameter int            AW        = 16,
    parameter int            DW        = 16,
    parameter logic [AW-1:0] LOAD_BASE = 16'h0000,
    parameter logic [AW-1:0] PORT_ADDR = 16'hFF00,
    parameter logic [AW-1:0] STAT_ADDR = 16'hFF02,
    parameter logic [DW-1:0] END_MARK  = 16'hA5A5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tc_si,
    input  logic          tc_shift,
    input  logic          tc_update,
    output logic          tc_so,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          irq,
    input  logic          irq_ack,
    input  logic          cpu_valid,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata
);
    import sbst_pkg::*;

    localparam int OPW  = 8;
    localparam int ARGW = DW;

    sbst_state_e     state;
    logic            cmd_valid;
    logic [OPW-1:0]  cmd_op;
    logic [ARGW-1:0] cmd_arg;
    logic            out_load;
    logic [DW-1:0]   out_val;
    logic [DW-1:0]   sig;
    logic            ld_last;
    logic            trig_arm;
    logic [AW-1:0]   trig_addr;

    logic is_run, can_start;
    logic load_go, data_go, run_go, stat_rd, rslt_rd, trig_go;
    logic port_hit, end_hit, trig_hit;

    sbst_cmd_port #(.OPW(OPW), .ARGW(ARGW), .OUTW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .si(tc_si), .shift(tc_shift), .update(tc_update),
        .out_load(out_load), .out_val(out_val), .so(tc_so),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg)
    );

    // Command acceptance per state; only read status passes while running.
    always_comb begin
        is_run    = (state == ST_RUN);
        can_start = (state == ST_IDLE) || (state == ST_DONE);
        load_go   = cmd_valid && (cmd_op == OP_LOAD) && can_start && (cmd_arg != '0);
        data_go   = cmd_valid && (cmd_op == OP_DATA) && (state == ST_LOAD);
        run_go    = cmd_valid && (cmd_op == OP_RUN)  && can_start;
        stat_rd   = cmd_valid && (cmd_op == OP_STAT);
        rslt_rd   = cmd_valid && (cmd_op == OP_RSLT) && !is_run;
        trig_go   = cmd_valid && (cmd_op == OP_TRIG) && !is_run;
    end

    // Processor-side event detection.
    always_comb begin
        port_hit = is_run && cpu_valid && cpu_we && (cpu_addr == PORT_ADDR);
        end_hit  = is_run && cpu_valid && cpu_we && (cpu_addr == STAT_ADDR)
                   && (cpu_wdata == END_MARK);
        trig_hit = trig_arm && cpu_valid && (cpu_addr == trig_addr);
    end

    // Readout source select.
    always_comb begin
        out_load = stat_rd || rslt_rd;
        out_val  = stat_rd ? {{(DW-2){1'b0}}, state} : sig;
    end

    sbst_loader #(.AW(AW), .DW(DW), .CW(ARGW), .BASE(LOAD_BASE)) u_load (
        .clk(clk), .rst_n(rst_n), .start(load_go), .count(cmd_arg),
        .word_valid(data_go), .word(cmd_arg), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .last_write(ld_last)
    );

    sbst_misr #(.W(DW), .POLY(16'h1021)) u_misr (
        .clk(clk), .rst_n(rst_n), .clear(run_go), .en(port_hit),
        .din(cpu_wdata), .sig(sig)
    );

    // Controller state sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else if (load_go) state <= ST_LOAD;
        else if (run_go)  state <= ST_RUN;
        else if ((state == ST_LOAD) && ld_last) state <= ST_IDLE;
        else if (end_hit) state <= ST_DONE;
    end

    // Interrupt request: set by run or trigger, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq <= 1'b0;
        else if (run_go || trig_hit) irq <= 1'b1;
        else if (irq_ack)           irq <= 1'b0;
    end

    // One-shot debug trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_arm  <= 1'b0;
            trig_addr <= '0;
        end else if (trig_go) begin
            trig_arm  <= 1'b1;
            trig_addr <= cmd_arg[AW-1:0];
        end else if (trig_hit) begin
            trig_arm  <= 1'b0;
        end
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R7
    AST_REQ_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (state == ST_LOAD)); // R3
    AST_RUN_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !bus_we); // R10
    AST_DONE_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        end_hit |=> (state == ST_DONE)); // R9
endmodule

// File: tb/sbst_ctrl_tb.sv
// Directed bench for the self-test controller.
module sbst_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tc_si = 1'b0, tc_shift = 1'b0, tc_update = 1'b0;
    logic tc_so;
    logic bus_req, bus_we, irq;
    logic bus_gnt = 1'b0;
    logic [15:0] bus_addr, bus_wdata;
    logic irq_ack = 1'b0, cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0, cpu_wdata = 16'h0;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int wr_n    = 0;
    int wr_bad  = 0;
    logic [15:0] wr_addr [8];
    logic [15:0] wr_data [8];
    logic [15:0] model;

    always #2.5 clk = ~clk;

    sbst_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tc_si(tc_si), .tc_shift(tc_shift),
        .tc_update(tc_update), .tc_so(tc_so), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .irq(irq),
        .irq_ack(irq_ack), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata)
    );

    // Record every bus write the block issues.
    always @(posedge clk) begin
        if (rst_n && bus_we) begin
            wr_addr[wr_n % 8] = bus_addr;
            wr_data[wr_n % 8] = bus_wdata;
            wr_n = wr_n + 1;
            if (!bus_gnt) wr_bad = wr_bad + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [15:0] misr_step(logic [15:0] s, logic [15:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] op, logic [15:0] arg);
        logic [23:0] w;
        w = {arg, op};
        for (int i = 0; i < 24; i++) begin
            tc_si = w[i];
            tc_shift = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        tc_shift = 1'b0;
        tc_si = 1'b0;
        tc_update = 1'b1;
        @(posedge clk); @(negedge clk);
        tc_update = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        for (int i = 0; i < 16; i++) begin
            v[i] = tc_so;
            tc_shift = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        tc_shift = 1'b0;
    endtask

    task automatic query(logic [7:0] op, output logic [15:0] v);
        send(op, 16'h0000);
        read16(v);
    endtask

    task automatic cpu_write(logic [15:0] a, logic [15:0] d);
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(logic [15:0] a);
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(posedge clk); @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", irq, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 bus_we", bus_we, 0);
        query(8'h03, v);
        check("R1 R11 status idle", v, 16'd0);
        query(8'h04, v);
        check("R1 R11 result zero", v, 16'h0000);
    endtask

    task automatic t_load();
        logic [15:0] v;
        bus_gnt = 1'b1;
        wr_n = 0;
        send(8'h01, 16'd3);
        check("R3 bus_req raised", bus_req, 1);
        query(8'h03, v);
        check("R2 R3 status loading", v, 16'd1);
        send(8'h05, 16'hC0DE);
        send(8'h05, 16'h1234);
        send(8'h05, 16'h8F01);
        @(negedge clk);
        check("R4 write count", wr_n, 3);
        check("R4 addr0", wr_addr[0], 16'h0000);
        check("R4 data0", wr_data[0], 16'hC0DE);
        check("R4 addr2", wr_addr[2], 16'h0002);
        check("R4 data2", wr_data[2], 16'h8F01);
        check("R4 idle bus_addr", bus_addr, 16'h0000);
        check("R6 bus_req released", bus_req, 0);
        query(8'h03, v);
        check("R6 status idle", v, 16'd0);
    endtask

    task automatic t_stall();
        bus_gnt = 1'b0;
        wr_n = 0;
        send(8'h01, 16'd1);
        send(8'h05, 16'h5A5A);
        repeat (5) @(negedge clk);
        check("R5 no write without grant", wr_n, 0);
        check("R5 request held", bus_req, 1);
        bus_gnt = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 write after grant", wr_n, 1);
        check("R5 data", wr_data[0], 16'h5A5A);
        check("R5 addr restarts at base", wr_addr[0], 16'h0000);
        check("R6 req low", bus_req, 0);
        check("R5 no ungranted strobe", wr_bad, 0);
    endtask

    task automatic t_run();
        logic [15:0] v;
        send(8'h02, 16'h0000);
        check("R7 irq raised", irq, 1);
        repeat (3) @(negedge clk);
        check("R7 irq held", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R7 irq cleared by ack", irq, 0);
        query(8'h03, v);
        check("R7 status running", v, 16'd2);
        model = 16'h0000;
        cpu_write(16'hFF00, 16'h1111); model = misr_step(model, 16'h1111);
        cpu_write(16'hFF00, 16'h8001); model = misr_step(model, 16'h8001);
        cpu_write(16'hFF00, 16'hBEEF); model = misr_step(model, 16'hBEEF);
        cpu_write(16'hFF04, 16'h7777);
        cpu_read(16'hFF00);
        // R10: commands other than status are ignored while running.
        query(8'h04, v);
        check("R10 result read ignored", v, 16'h0000);
        wr_n = 0;
        send(8'h01, 16'd2);
        @(negedge clk);
        check("R10 load ignored", bus_req, 0);
        send(8'h02, 16'h0000);
        check("R10 run ignored, no irq", irq, 0);
        cpu_write(16'hFF02, 16'h1234);
        query(8'h03, v);
        check("R9 non-marker no effect", v, 16'd2);
        cpu_write(16'hFF02, 16'hA5A5);
        query(8'h03, v);
        check("R9 status done", v, 16'd3);
        cpu_write(16'hFF00, 16'h0F0F);
        query(8'h04, v);
        check("R8 R9 signature", v, model);
    endtask

    task automatic t_trigger();
        logic [15:0] v;
        send(8'h06, 16'h0040);
        cpu_read(16'h0041);
        check("R12 no match no irq", irq, 0);
        cpu_read(16'h0040);
        check("R12 match raises irq", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        cpu_read(16'h0040);
        check("R12 one-shot", irq, 0);
        send(8'h02, 16'h0000);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        cpu_write(16'hFF02, 16'hA5A5);
        query(8'h04, v);
        check("R7 signature cleared on run", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_stall();
        t_run();
        t_trigger();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule